// File: doc/BRIEF.md
# Serial Control Register File for a Multi-Channel Audio Converter

This block receives control words over a write-only three-wire port, made of a data line, a shift clock and a latch strobe. It decodes each word into a small set of control registers. The outputs are six effective 8-bit attenuation levels, one for each side of three stereo pairs, and a set of decoded mode fields. The mode fields cover soft mute, de-emphasis, operation disable, word length, output routing, data format, frame polarity, sample-rate group and the zero-detect enable.

The host shifts 16 bits per word, most significant bit first. The top three bits are a don't-care prefix. They are followed by a 4-bit register address and then 9 data bits. A rising edge on the latch line commits the word. The serial port may run with no phase relation to the core clock. For that reason the word is frozen in the serial domain at the latch edge, and only the latch event is carried into the core domain.

Attenuation writes are staged. A level takes effect only when the word carries its load bit. A master address sets all six channels together. A mode bit makes each pair's right output follow that pair's left level.

Top module: `ctl3w_regfile`

## Requirements
- R1: After reset, every attenuation output is 8'hFF (0 dB). The routing field is 4'b1001 and every other mode output is 0.
- R2: A word is the last bits shifted on rising shift-clock edges, MSB first. Word bits [12:9] are the address and bits [8:0] are the data. The word is committed by a rising latch edge. Its effect appears at the outputs by the third rising core clock edge after that latch edge.
- R3: Addresses 0/1, 4/5 and 6/7 are the left/right attenuation of pairs 0, 1 and 2. Output channel c sits at att_lvl[8c+7:8c], in the order L0, R0, L1, R1, L2, R2. A write with data bit 8 = 1 sets that channel's effective level to data[7:0].
- R4: An attenuation write with data bit 8 = 0 leaves every attenuation output unchanged.
- R5: Address 2 sets mute = bit 0, deemph = bit 1, op_dis = bit 2, wlen = bits 4:3 and route = bits 8:5.
- R6: Address 3 sets fmt_i2s = bit 0, lr_pol = bit 1, att_common = bit 2, sr_grp = bits 7:6 and zdet_en = bit 8. Bits 5:3 have no effect.
- R7: While att_common = 1, each pair's right output shows that pair's left effective level. Clearing att_common again shows the right channel's own last loaded level.
- R8: Address 8 with data bit 8 = 1 sets all six effective levels to data[7:0]. With bit 8 = 0, no output changes.
- R9: Writes to addresses 9 to 15 change no output. The three prefix bits never affect decoding.
- R10: Asserting rst_n low at any time returns every output to its R1 value.
- R11: If more than 16 bits are shifted before a latch, only the final 16 determine the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_clk | input | 1 | Serial shift clock, data sampled on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch strobe, rising edge commits the word |
| att_lvl | output | 48 | Six effective 8-bit attenuation levels, channel c at [8c+7:8c] |
| mute | output | 1 | Soft mute request |
| deemph | output | 1 | De-emphasis enable |
| op_dis | output | 1 | Operation disable |
| wlen | output | 2 | Input word length code |
| route | output | 4 | Output routing code |
| fmt_i2s | output | 1 | Data format select |
| lr_pol | output | 1 | Frame clock polarity |
| att_common | output | 1 | Right channels follow left levels |
| sr_grp | output | 2 | Sample-rate group |
| zdet_en | output | 1 | Zero-detect automute enable |

## Verification
A committed word passes through two synchronizer flops and one edge-detect flop, so every output reflects it by the third core edge after the latch rises. Outputs are combinational from the registered state. The bench therefore holds the latch high for eight core cycles, waits a further eight after dropping it, and samples mid-cycle, well past that point. Checks for ignored writes sample at the same point, so an erroneous update would already be visible. The bound checker also requires the outputs to hold still in every cycle without a commit.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
    localparam int LVL_W   = 8;
    localparam int DATA_W  = LVL_W + 1;
    localparam int ADDR_W  = 4;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int NPAIR   = 3;
    localparam int NCH     = 2 * NPAIR;

    localparam logic [LVL_W-1:0]  LVL_DEFAULT   = '1;
    localparam logic [3:0]        ROUTE_DEFAULT = 4'b1001;
    localparam logic [ADDR_W-1:0] ADDR_MODE     = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_FMT      = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_MASTER   = 4'd8;
    localparam int                PAIR1_BASE    = 4;

    typedef struct packed {
        logic [3:0] route;
        logic [1:0] wlen;
        logic       op_dis;
        logic       deemph;
        logic       mute;
    } mode_t;

    typedef struct packed {
        logic       zdet_en;
        logic [1:0] sr_grp;
        logic       att_common;
        logic       lr_pol;
        logic       fmt_i2s;
    } fmt_t;

    typedef logic [NCH-1:0][LVL_W-1:0] lvl_arr_t;

    // Channel slot for an attenuation address, -1 when none
    function automatic int att_slot(input logic [ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        if (ai < 2) return ai;
        if (ai >= PAIR1_BASE && ai < PAIR1_BASE + 2 * (NPAIR - 1)) return ai - 2;
        return -1;
    endfunction
endpackage

// File: rtl/ctl3w_shifter.sv
`timescale 1ns/1ps
module ctl3w_shifter #(
    parameter int FRAME_W = 13
) (
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               ser_lat,
    output logic [FRAME_W-1:0] frame_o
);
    // Only the last FRAME_W bits are kept; the prefix bits fall off the top
    logic [FRAME_W-1:0] shift_q;
    logic [FRAME_W-1:0] hold_q;

    always_ff @(posedge ser_clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[FRAME_W-2:0], ser_dat};
    end

    // Frozen at the latch edge, stable while the core picks it up
    always_ff @(posedge ser_lat or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= shift_q;
    end

    assign frame_o = hold_q;
endmodule

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], async_i};
    end

    // One core cycle pulse on each synchronized rising edge
    assign pulse_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ctl3w_regs.sv
`timescale 1ns/1ps
module ctl3w_regs
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output lvl_arr_t          eff_o,
    output mode_t             mode_o,
    output fmt_t              fmt_o
);
    typedef struct packed {
        lvl_arr_t eff;
        mode_t    mode;
        fmt_t     fmt;
    } state_t;

    state_t st_d, st_q;

    logic [LVL_W-1:0] lvl;
    logic             ld;
    int               slot;

    always_comb begin
        st_d = st_q;
        lvl  = data[LVL_W-1:0];
        ld   = data[DATA_W-1];
        slot = att_slot(addr);
        if (commit) begin
            if (addr == ADDR_MODE) begin
                st_d.mode.mute   = data[0];
                st_d.mode.deemph = data[1];
                st_d.mode.op_dis = data[2];
                st_d.mode.wlen   = data[4:3];
                st_d.mode.route  = data[8:5];
            end else if (addr == ADDR_FMT) begin
                st_d.fmt.fmt_i2s    = data[0];
                st_d.fmt.lr_pol     = data[1];
                st_d.fmt.att_common = data[2];
                st_d.fmt.sr_grp     = data[7:6];
                st_d.fmt.zdet_en    = data[8];
            end else if (addr == ADDR_MASTER) begin
                if (ld) begin
                    for (int ch = 0; ch < NCH; ch++) st_d.eff[ch] = lvl;
                end
            end else if (ld) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (slot == ch) st_d.eff[ch] = lvl;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) st_q.eff[ch] <= LVL_DEFAULT;
            st_q.mode       <= '0;
            st_q.mode.route <= ROUTE_DEFAULT;
            st_q.fmt        <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_o  = st_q.eff;
    assign mode_o = st_q.mode;
    assign fmt_o  = st_q.fmt;
endmodule

// File: rtl/ctl3w_regfile.sv
`timescale 1ns/1ps
module ctl3w_regfile
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_lat,
    output logic [NCH*LVL_W-1:0] att_lvl,
    output logic                 mute,
    output logic                 deemph,
    output logic                 op_dis,
    output logic [1:0]           wlen,
    output logic [3:0]           route,
    output logic                 fmt_i2s,
    output logic                 lr_pol,
    output logic                 att_common,
    output logic [1:0]           sr_grp,
    output logic                 zdet_en
);
    logic [FRAME_W-1:0] frame;
    logic               commit;
    lvl_arr_t           eff;
    mode_t              mode;
    fmt_t               fmt;

    ctl3w_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .ser_lat (ser_lat),
        .frame_o (frame)
    );

    ctl3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ser_lat),
        .pulse_o (commit)
    );

    ctl3w_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .addr   (frame[FRAME_W-1:DATA_W]),
        .data   (frame[DATA_W-1:0]),
        .eff_o  (eff),
        .mode_o (mode),
        .fmt_o  (fmt)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign att_lvl[(2*p)*LVL_W +: LVL_W]   = eff[2*p];
        assign att_lvl[(2*p+1)*LVL_W +: LVL_W] = fmt.att_common ? eff[2*p] : eff[2*p+1];
    end

    assign mute       = mode.mute;
    assign deemph     = mode.deemph;
    assign op_dis     = mode.op_dis;
    assign wlen       = mode.wlen;
    assign route      = mode.route;
    assign fmt_i2s    = fmt.fmt_i2s;
    assign lr_pol     = fmt.lr_pol;
    assign att_common = fmt.att_common;
    assign sr_grp     = fmt.sr_grp;
    assign zdet_en    = fmt.zdet_en;
endmodule

// File: rtl/ctl3w_regfile_chk.sv
`timescale 1ns/1ps
module ctl3w_regfile_chk
    import ctl3w_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 commit,
    input logic [FRAME_W-1:0]   frame,
    input logic [NCH*LVL_W-1:0] att_lvl,
    input logic                 mute,
    input logic                 deemph,
    input logic                 op_dis,
    input logic [1:0]           wlen,
    input logic [3:0]           route,
    input logic                 fmt_i2s,
    input logic                 lr_pol,
    input logic                 att_common,
    input logic [1:0]           sr_grp,
    input logic                 zdet_en
);
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic [22:0]       outs;
    logic              is_att;

    assign a      = frame[FRAME_W-1:DATA_W];
    assign d      = frame[DATA_W-1:0];
    assign outs   = {route, wlen, op_dis, deemph, mute,
                     zdet_en, sr_grp, att_common, lr_pol, fmt_i2s, 8'h00};
    assign is_att = (att_slot(a) >= 0);

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(att_lvl) && $stable(outs)));

    assert_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && is_att && !d[DATA_W-1]) |=> $stable(att_lvl));

    assert_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && a == ADDR_MODE) |=> ({route, wlen, op_dis, deemph, mute} == $past(d)));

    assert_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && a == ADDR_FMT) |=>
        ({zdet_en, sr_grp, att_common, lr_pol, fmt_i2s} == {$past(d[8]), $past(d[7:6]), $past(d[2:0])}));

    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && a > ADDR_MASTER) |=> ($stable(att_lvl) && $stable(outs)));

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
        assert_common_R7: assert property (@(posedge clk) disable iff (!rst_n)
            att_common |-> (att_lvl[(2*p+1)*LVL_W +: LVL_W] == att_lvl[(2*p)*LVL_W +: LVL_W]));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
        assert_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && a == ADDR_MASTER && d[DATA_W-1]) |=>
            (att_lvl[c*LVL_W +: LVL_W] == $past(d[LVL_W-1:0])));
    end
endmodule

bind ctl3w_regfile ctl3w_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .frame      (frame),
    .att_lvl    (att_lvl),
    .mute       (mute),
    .deemph     (deemph),
    .op_dis     (op_dis),
    .wlen       (wlen),
    .route      (route),
    .fmt_i2s    (fmt_i2s),
    .lr_pol     (lr_pol),
    .att_common (att_common),
    .sr_grp     (sr_grp),
    .zdet_en    (zdet_en)
);

// File: tb/ctl3w_regfile_test.sv
`timescale 1ns/1ps
module ctl3w_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_lat = 1'b0;
    logic [47:0] att_lvl;
    logic        mute, deemph, op_dis, fmt_i2s, lr_pol, att_common, zdet_en;
    logic [1:0]  wlen, sr_grp;
    logic [3:0]  route;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ctl3w_regfile uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .att_lvl(att_lvl), .mute(mute), .deemph(deemph), .op_dis(op_dis), .wlen(wlen),
        .route(route), .fmt_i2s(fmt_i2s), .lr_pol(lr_pol), .att_common(att_common),
        .sr_grp(sr_grp), .zdet_en(zdet_en)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] lv(input logic [7:0] l0, r0, l1, r1, l2, r2);
        return {r2, l2, r1, l1, r0, l0};
    endfunction

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            #20 ser_clk = 1'b1;
            #20 ser_clk = 1'b0;
        end
    endtask

    task automatic latch();
        #10 ser_lat = 1'b1;
        repeat (8) @(posedge clk);
        ser_lat = 1'b0;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [2:0] pre, input logic [3:0] addr, input logic [8:0] data);
        shift_bits({16'h0, pre, addr, data}, 16);
        latch();
    endtask

    task automatic do_reset();
        #1 rst_n = 1'b0;
        #12 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic check_defaults(input string req);
        check(req, att_lvl, {6{8'hFF}});
        check(req, {44'h0, route}, 48'h9);
        check(req, {37'h0, mute, deemph, op_dis, wlen, fmt_i2s, lr_pol, att_common, sr_grp, zdet_en}, 48'h0);
    endtask

    task automatic t_reset();
        check_defaults("R1");
    endtask

    task automatic t_channels();
        send(3'b000, 4'd0, 9'h110);
        send(3'b000, 4'd1, 9'h121);
        send(3'b000, 4'd4, 9'h132);
        send(3'b000, 4'd5, 9'h143);
        send(3'b000, 4'd6, 9'h154);
        send(3'b000, 4'd7, 9'h165);
        check("R3 R2 per-channel load", att_lvl, lv(8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65));
    endtask

    task automatic t_staged();
        send(3'b000, 4'd1, 9'h012);
        check("R4 staged right0", att_lvl, lv(8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65));
        send(3'b000, 4'd6, 9'h000);
        check("R4 staged left2", att_lvl, lv(8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65));
    endtask

    task automatic t_mode();
        send(3'b000, 4'd2, 9'h16D);
        check("R5 route", {44'h0, route}, 48'hB);
        check("R5 wlen", {46'h0, wlen}, 48'h1);
        check("R5 flags", {45'h0, op_dis, deemph, mute}, 48'h5);
    endtask

    task automatic t_fmt();
        send(3'b000, 4'd3, 9'h1BA);
        check("R6 fields", {42'h0, zdet_en, sr_grp, att_common, lr_pol, fmt_i2s}, {42'h0, 6'b110010});
        check("R6 levels untouched", att_lvl, lv(8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65));
    endtask

    task automatic t_common();
        send(3'b000, 4'd3, 9'h004);
        check("R7 common on", att_lvl, lv(8'h10, 8'h10, 8'h32, 8'h32, 8'h54, 8'h54));
        send(3'b000, 4'd3, 9'h000);
        check("R7 common off", att_lvl, lv(8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65));
    endtask

    task automatic t_master();
        send(3'b000, 4'd8, 9'h140);
        check("R8 master load", att_lvl, {6{8'h40}});
        send(3'b000, 4'd8, 9'h011);
        check("R8 master staged", att_lvl, {6{8'h40}});
    endtask

    task automatic t_unused();
        for (int a = 9; a < 16; a++) begin
            send(3'b000, 4'(a), 9'h1AA);
            check("R9 unused addr levels", att_lvl, {6{8'h40}});
            check("R9 unused addr mode", {37'h0, route, wlen, op_dis, deemph, mute, zdet_en, sr_grp},
                  {37'h0, 4'hB, 2'b01, 3'b101, 3'b000});
        end
        send(3'b111, 4'd5, 9'h177);
        check("R9 prefix ignored", att_lvl, lv(8'h40, 8'h40, 8'h40, 8'h77, 8'h40, 8'h40));
    endtask

    task automatic t_long();
        shift_bits({12'h0, 4'hF, 3'b000, 4'd0, 9'h1C3}, 20);
        latch();
        check("R11 long word", att_lvl, lv(8'hC3, 8'h40, 8'h40, 8'h77, 8'h40, 8'h40));
    endtask

    task automatic t_async_reset();
        send(3'b000, 4'd3, 9'h1C7);
        do_reset();
        check_defaults("R10");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_channels();
        t_staged();
        t_mode();
        t_fmt();
        t_common();
        t_master();
        t_unused();
        t_long();
        t_async_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule